// File: doc/BRIEF.md
# Multi-Region Memory Access Sequencer

The sequencer sits between one bus master and three on-chip storage regions: a small I/O register file, a data SRAM and an EEPROM page buffer. It decodes every request address into a region and completes the access with that region's timing. Writes finish in one cycle in every region. Reads take one, two or three cycles depending on the region. Burst reads then deliver further words at the pace the region allows: every cycle for I/O and SRAM, and every second cycle for the EEPROM buffer.

The master drives `req` with address, write enable, write data, a burst flag and a burst length, and holds them until it sees `ready` high in the same cycle. That cycle is the acceptance cycle. Read data is valid only in cycles where `rvalid` is high. While a multi-cycle read or a burst is running, `ready` stays low and the sequencer takes no new request.

The controller has three named states:
- `S_IDLE`: ready for a request.
- `S_LEAD`: counting the first-word latency.
- `S_BURST`: pacing the remaining words.

Its transitions are:
- IDLE→IDLE on a write, an error access, a single I/O read, or no request.
- IDLE→LEAD on a read of SRAM or EEPROM.
- IDLE→BURST on an I/O burst of more than one word.
- LEAD→BURST when the first word goes out and more words remain.
- LEAD→IDLE when the only word goes out.
- BURST→IDLE when the last word goes out.

Top module: `mem_access_seq`

## Requirements
- R1: The address decode is:
  - 0x0000–0x0FFF selects I/O.
  - 0x1000–0x1FFF selects EEPROM.
  - 0x2000–0x3FFF selects SRAM.

  Each storage array is indexed by the low address bits: 6 bits for I/O and EEPROM, 8 bits for SRAM. Addresses that differ only above those bits therefore alias to the same location.
- R2: An address at 0x4000 or above is accepted in one cycle. `err` is high for exactly the next cycle. No `rvalid` follows, no storage changes, and the burst flag is ignored.
- R3: A write to any region updates the storage at the edge that ends the acceptance cycle. `ready` stays high in the next cycle, and no `rvalid` is produced.
- R4: A single I/O read gives `rvalid` one cycle after acceptance, and `ready` stays high throughout.
- R5: A single SRAM read gives `rvalid` two cycles after acceptance, with `ready` low in the cycle between.
- R6: A single EEPROM read gives `rvalid` three cycles after acceptance.
- R7: An SRAM burst of N words delivers words at acceptance + 2, +3, … +N+1. The address rises by one per word.
- R8: An EEPROM burst of N words delivers words at acceptance + 3, +5, … +2N+1, with `rvalid` low in the cycles between.
- R9: An I/O burst of N words delivers words at acceptance + 1 through +N.
- R10: A burst length of 0 reads one word. The burst flag has no effect on writes: a single write is made.
- R11: After a multi-cycle read is accepted, `ready` is low until the cycle that carries its last word. That cycle has `ready` high again. A request held during the busy cycles is neither accepted nor written.
- R12: During and right after reset, `ready` is high and `rvalid` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request, held until accepted |
| addr | input | 16 | Word address |
| wr_en | input | 1 | 1 = write, 0 = read |
| wdata | input | 8 | Write data |
| burst | input | 1 | Burst read request |
| burst_len | input | 8 | Burst word count (0 treated as 1) |
| ready | output | 1 | Request accepted in this cycle when `req` is high |
| rvalid | output | 1 | Read data valid |
| rdata | output | 8 | Read data |
| err | output | 1 | Out-of-range access completed |

## Verification
The bench builds the block with its default parameters: 6-bit I/O and EEPROM indexes and an 8-bit SRAM index. With arrays that small, aliasing across a whole region is reached with a single write to a high address. Each burst here is at most four words long, so the 8-bit length field is never near its limit. Within that range the bench reaches every latency, each pacing pattern and the busy window. It holds a write request across an EEPROM burst to show that nothing is taken early.

// File: rtl/mas_pkg.sv
package mas_pkg;

    typedef enum logic [1:0] {
        RG_IO   = 2'd0,
        RG_EE   = 2'd1,
        RG_SR   = 2'd2,
        RG_NONE = 2'd3
    } region_t;

    localparam int NUM_BANKS = 3;

    // cycles from acceptance to the first read word
    function automatic logic [1:0] first_lat(region_t r);
        unique case (r)
            RG_EE:   first_lat = 2'd3;
            RG_SR:   first_lat = 2'd2;
            default: first_lat = 2'd1;
        endcase
    endfunction

    // cycles between successive burst words
    function automatic logic [1:0] pace_gap(region_t r);
        pace_gap = (r == RG_EE) ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/mas_decode.sv
module mas_decode
    import mas_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int IO_LIMIT = 32'h1000,
    parameter int EE_LIMIT = 32'h2000,
    parameter int SR_LIMIT = 32'h4000
) (
    input  logic [ADDR_W-1:0] addr_i,
    output region_t           region_o
);
    logic [31:0] a32;

    always_comb begin
        a32 = 32'(addr_i);
        if (a32 < 32'(IO_LIMIT))      region_o = RG_IO;
        else if (a32 < 32'(EE_LIMIT)) region_o = RG_EE;
        else if (a32 < 32'(SR_LIMIT)) region_o = RG_SR;
        else                          region_o = RG_NONE;
    end
endmodule

// File: rtl/mas_bank.sv
module mas_bank #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/mas_ctrl.sv
module mas_ctrl
    import mas_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              wr_en_i,
    input  logic              burst_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  region_t           region_i,
    input  logic [DATA_W-1:0] bank_data_i,
    output logic              ready_o,
    output logic              rvalid_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              err_o,
    output region_t           rd_region_o,
    output logic [ADDR_W-1:0] rd_addr_o
);
    typedef enum logic [1:0] {S_IDLE, S_LEAD, S_BURST} state_t;

    state_t            state_q, state_d;
    region_t           region_q, region_d;
    logic [ADDR_W-1:0] ptr_q, ptr_d;
    logic [LEN_W-1:0]  left_q, left_d, words;
    logic [1:0]        wait_q, wait_d;
    logic              accept, emit, err_d;

    assign accept  = req_i && (state_q == S_IDLE);
    assign ready_o = (state_q == S_IDLE);
    assign words   = (burst_i && len_i != '0) ? len_i : LEN_W'(1);

    always_comb begin
        rd_region_o = accept ? region_i : region_q;
        rd_addr_o   = accept ? addr_i   : ptr_q;
    end

    // next-state and emit logic
    always_comb begin
        state_d  = state_q;
        region_d = region_q;
        ptr_d    = ptr_q;
        left_d   = left_q;
        wait_d   = wait_q;
        emit     = 1'b0;
        err_d    = accept && (region_i == RG_NONE);
        unique case (state_q)
            S_IDLE: begin
                if (accept && !wr_en_i && region_i != RG_NONE) begin
                    region_d = region_i;
                    if (first_lat(region_i) == 2'd1) begin
                        emit    = 1'b1;
                        ptr_d   = addr_i + 1'b1;
                        left_d  = words - 1'b1;
                        wait_d  = pace_gap(region_i);
                        state_d = (words == LEN_W'(1)) ? S_IDLE : S_BURST;
                    end else begin
                        ptr_d   = addr_i;
                        left_d  = words;
                        wait_d  = first_lat(region_i) - 2'd1;
                        state_d = S_LEAD;
                    end
                end
            end
            S_LEAD, S_BURST: begin
                if (wait_q == 2'd1) begin
                    emit    = 1'b1;
                    ptr_d   = ptr_q + 1'b1;
                    left_d  = left_q - 1'b1;
                    wait_d  = pace_gap(region_q);
                    state_d = (left_q == LEN_W'(1)) ? S_IDLE : S_BURST;
                end else begin
                    wait_d = wait_q - 2'd1;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            region_q <= RG_NONE;
            ptr_q    <= '0;
            left_q   <= '0;
            wait_q   <= '0;
        end else begin
            state_q  <= state_d;
            region_q <= region_d;
            ptr_q    <= ptr_d;
            left_q   <= left_d;
            wait_q   <= wait_d;
        end
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_o <= 1'b0;
            rdata_o  <= '0;
            err_o    <= 1'b0;
        end else begin
            rvalid_o <= emit;
            err_o    <= err_d;
            if (emit) rdata_o <= bank_data_i;
        end
    end

    assert_err_no_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !rvalid_o);

    assert_err_only_oob_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && region_i != RG_NONE) |=> !err_o);

    assert_write_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && wr_en_i) |=> (!rvalid_o && ready_o));

    assert_io_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !wr_en_i && region_i == RG_IO) |=> rvalid_o);

    assert_sram_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !wr_en_i && region_i == RG_SR) |=> (!rvalid_o && !ready_o));

    assert_ee_pace_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid_o && region_q == RG_EE && state_q != S_IDLE) |=> !rvalid_o);
endmodule

// File: rtl/mem_access_seq.sv
module mem_access_seq
    import mas_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int LEN_W  = 8,
    parameter int IO_AW  = 6,
    parameter int EE_AW  = 6,
    parameter int SR_AW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              burst,
    input  logic [LEN_W-1:0]  burst_len,
    output logic              ready,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata,
    output logic              err
);
    region_t           region, rd_region;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] bank_rd [NUM_BANKS];
    logic [DATA_W-1:0] bank_data;
    logic              wr_fire;

    mas_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i   (addr),
        .region_o (region)
    );

    assign wr_fire = req && ready && wr_en && (region != RG_NONE);

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        localparam int AW = (g == 0) ? IO_AW : (g == 1) ? EE_AW : SR_AW;
        mas_bank #(.AW(AW), .DW(DATA_W)) u_bank (
            .clk     (clk),
            .we_i    (wr_fire && (int'(region) == g)),
            .waddr_i (addr[AW-1:0]),
            .wdata_i (wdata),
            .raddr_i (rd_addr[AW-1:0]),
            .rdata_o (bank_rd[g])
        );
    end

    always_comb begin
        bank_data = '0;
        if (rd_region != RG_NONE) bank_data = bank_rd[int'(rd_region)];
    end

    mas_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .wr_en_i     (wr_en),
        .burst_i     (burst),
        .len_i       (burst_len),
        .addr_i      (addr),
        .region_i    (region),
        .bank_data_i (bank_data),
        .ready_o     (ready),
        .rvalid_o    (rvalid),
        .rdata_o     (rdata),
        .err_o       (err),
        .rd_region_o (rd_region),
        .rd_addr_o   (rd_addr)
    );
endmodule

// File: tb/mem_access_seq_test.sv
`timescale 1ns/1ps
module mem_access_seq_test;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req = 1'b0, wr_en = 1'b0, burst = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0, burst_len = '0;
    logic        ready, rvalid, err;
    logic [7:0]  rdata;

    mem_access_seq uut (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .wr_en(wr_en),
        .wdata(wdata), .burst(burst), .burst_len(burst_len),
        .ready(ready), .rvalid(rvalid), .rdata(rdata), .err(err)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, fails = 0;
    logic [7:0] mio [64];
    logic [7:0] mee [64];
    logic [7:0] msr [256];
    logic [7:0] exp_d [int];
    string      exp_t [int];
    bit         exp_e [int];
    int         free_at = 0;
    string      cur_tag = "R12";

    typedef struct {
        logic [15:0] a; bit w; logic [7:0] d; bit b; logic [7:0] n; int gap; string tag;
    } item_t;
    item_t q[$];

    function automatic int reg_of(logic [15:0] a);
        if (a < 16'h1000) return 0;
        if (a < 16'h2000) return 1;
        if (a < 16'h4000) return 2;
        return 3;
    endfunction

    function automatic logic [7:0] mrd(int r, logic [15:0] a);
        if (r == 0) return mio[a[5:0]];
        if (r == 1) return mee[a[5:0]];
        return msr[a[7:0]];
    endfunction

    task automatic check(string tag, string what, int act, int expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, expv, cyc);
        end
    endtask

    task automatic add(logic [15:0] a, bit w, logic [7:0] d, bit b, logic [7:0] n,
                       int gap, string tag);
        item_t it;
        it.a = a; it.w = w; it.d = d; it.b = b; it.n = n; it.gap = gap; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic model_accept(item_t it, int c);
        int r, n, lat, gp, t;
        r = reg_of(it.a);
        cur_tag = it.tag;
        free_at = c + 1;
        if (r == 3) begin
            exp_e[c+1] = 1'b1;
        end else if (it.w) begin
            if (r == 0) mio[it.a[5:0]] = it.d;
            else if (r == 1) mee[it.a[5:0]] = it.d;
            else msr[it.a[7:0]] = it.d;
        end else begin
            n   = (it.b && it.n != 0) ? int'(it.n) : 1;
            lat = (r == 0) ? 1 : (r == 1) ? 3 : 2;
            gp  = (r == 1) ? 2 : 1;
            for (int i = 0; i < n; i++) begin
                t = c + lat + gp * i;
                exp_d[t] = mrd(r, it.a + 16'(i));
                exp_t[t] = it.tag;
                if (t > free_at) free_at = t;
            end
        end
    endtask

    task automatic compare();
        string tg;
        tg = exp_t.exists(cyc) ? exp_t[cyc] : cur_tag;
        check("R11", "ready", int'(ready), int'(cyc >= free_at));
        check(tg, "rvalid", int'(rvalid), int'(exp_d.exists(cyc)));
        if (exp_d.exists(cyc) && rvalid) check(tg, "rdata", int'(rdata), int'(exp_d[cyc]));
        check("R2", "err", int'(err), int'(exp_e.exists(cyc)));
    endtask

    initial begin
        #(4 * 20000);
        fails++; checks++;
        $display("FAIL R11 watchdog expired at cycle %0d", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // setup writes (R3)
        add(16'h0004, 1, 8'h11, 0, 0, 0, "R3");
        add(16'h0005, 1, 8'h22, 0, 0, 0, "R3");
        add(16'h0006, 1, 8'h33, 0, 0, 0, "R3");
        for (int i = 0; i < 5; i++) add(16'h2010 + 16'(i), 1, 8'h40 + 8'(i), 0, 0, 0, "R3");
        add(16'h2020, 1, 8'h50, 0, 0, 0, "R3");
        add(16'h2021, 1, 8'h51, 0, 0, 0, "R3");
        for (int i = 0; i < 3; i++) add(16'h1003 + 16'(i), 1, 8'h60 + 8'(i), 0, 0, 0, "R3");
        add(16'h5000, 1, 8'hAB, 0, 0, 1, "R2");      // out-of-range write
        // single reads
        add(16'h0005, 0, 0, 0, 0, 0, "R4");
        add(16'h0006, 0, 0, 0, 0, 0, "R4");
        add(16'h2010, 0, 0, 0, 0, 0, "R5");
        add(16'h1003, 0, 0, 0, 0, 0, "R6");
        // bursts
        add(16'h2010, 0, 0, 1, 4, 1, "R7");
        add(16'h1003, 0, 0, 1, 3, 0, "R8");
        add(16'h1004, 1, 8'hEE, 0, 0, 0, "R11");     // held through the burst
        add(16'h1004, 0, 0, 0, 0, 0, "R6");
        add(16'h0004, 0, 0, 1, 3, 0, "R9");
        add(16'h2014, 0, 0, 1, 0, 0, "R10");          // length 0
        add(16'h2020, 1, 8'h77, 1, 4, 0, "R10");      // burst flag on a write
        add(16'h2021, 0, 0, 0, 0, 0, "R10");
        add(16'h2020, 0, 0, 0, 0, 0, "R10");
        add(16'h8000, 0, 0, 1, 3, 2, "R2");           // out-of-range burst read
        add(16'h2010, 0, 0, 0, 0, 0, "R2");
        // aliasing
        add(16'h0FC5, 1, 8'h99, 0, 0, 0, "R1");
        add(16'h0005, 0, 0, 0, 0, 0, "R1");
        add(16'h3F10, 0, 0, 0, 0, 0, "R1");
        add(16'h17C3, 0, 0, 0, 0, 0, "R1");

        repeat (3) @(negedge clk);
        check("R12", "ready in reset", int'(ready), 1);
        check("R12", "rvalid in reset", int'(rvalid), 0);
        check("R12", "err in reset", int'(err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12", "ready after reset", int'(ready), 1);
        check("R12", "rvalid after reset", int'(rvalid), 0);
        free_at = cyc;
        while (q.size() > 0 || cyc <= free_at + 3) begin
            @(negedge clk);
            compare();
            if (q.size() > 0 && q[0].gap > 0) begin
                q[0].gap--;
                req = 1'b0;
            end else if (q.size() > 0) begin
                req = 1'b1; addr = q[0].a; wr_en = q[0].w; wdata = q[0].d;
                burst = q[0].b; burst_len = q[0].n;
                if (cyc >= free_at) begin
                    model_accept(q[0], cyc);
                    void'(q.pop_front());
                end
            end else begin
                req = 1'b0;
            end
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule